// File: doc/BRIEF.md
# Memory-mapped GPIO controller with interrupt detection

This block is a general-purpose I/O controller that sits behind an APB slave interface. It has up to four ports of up to 32 bits each. Every port has an output data register and a direction register that drive the pad-side outputs directly. Every port also has a read-only register that shows the pin levels after a two-flop synchronizer.

The first port, port 0, adds per-bit interrupt detection. Each bit has its own enable, mask, sensing type (level or edge) and polarity. Edge events stay latched until software writes a one to the matching bit of the end-of-interrupt register. An optional per-bit debounce filter holds back any input change until it has stayed stable for a parameterised number of debounce ticks. All status bits are combined into a single interrupt output. A build parameter moves five of the interrupt registers to a second offset layout.

Both-edge triggering is done by software, which flips a polarity bit after each event. Edges are therefore detected on the qualified input itself, never on the polarity-adjusted signal, so a polarity change can never look like an edge.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, `pin_out`, `pin_oe` and `irq` are 0, and `prdata` is 0.
- R2: Port p (p < NUM_PORTS) has its output data register at byte offset 12·p and its direction register at 12·p+4. Both are readable and writable. `pin_out` and `pin_oe` for bits [p·PORT_W +: PORT_W] show those registers one cycle after the write. A direction bit of 1 means output.
- R3: Offset 0x50+4·p returns the synchronized pins of port p. A write to it is ignored.
- R4: The bus has no wait states: `pready` is always 1 and `pslverr` is always 0. A read of any offset that is not mapped returns 0. The end-of-interrupt register also reads as 0.
- R5: Level sensing (type bit 0) on an enabled bit reports in status while the qualified input equals the polarity bit: a polarity of 1 means active high and 0 means active low. Status clears when the input goes inactive.
- R6: Edge sensing (type bit 1) with polarity 1 latches a rising edge. The latch holds after the pin returns low. Writing 1 to a bit of the end-of-interrupt register clears only that bit, and writing all ones clears every bit.
- R7: Edge sensing with polarity 0 latches a falling edge. Changing a polarity bit while the pin is steady latches nothing.
- R8: A mask bit of 1 hides that line from status and from `irq`. A latched edge reappears in status when the mask bit is cleared.
- R9: A line whose enable bit is 0 reports nothing in status, whatever its type, polarity or pin activity.
- R10: With its debounce bit set, a port-0 input change is accepted only after it differs from the accepted level on DB_TICKS consecutive `db_tick` pulses. A shorter pulse causes no interrupt. The debounce enable register reads back what was written.
- R11: The default layout places enable at 0x30, mask at 0x34, type at 0x38, polarity at 0x3c, status at 0x40, debounce at 0x48 and end-of-interrupt at 0x4c. With ALT_LAYOUT=1, type moves to 0x34, polarity to 0x38, status to 0x3c, end-of-interrupt to 0x40 and mask to 0x44. Enable and debounce stay where they are.
- R12: `irq` is the OR of the status bits. A write to the status register is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, registered in the setup phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| db_tick | input | 1 | Debounce sampling strobe |
| pin_in | input | NUM_PORTS*PORT_W | External pin levels, port p at bits [p*PORT_W +: PORT_W] |
| pin_out | output | NUM_PORTS*PORT_W | Output data to the pads |
| pin_oe | output | NUM_PORTS*PORT_W | Output enable to the pads |
| irq | output | 1 | Combined interrupt |

## Verification
The interrupt logic is driven with four kinds of pin pattern:
- Level high and level low, with the pin held and then released. This separates sensing that tracks the input from sensing that latches.
- Single rising and falling edges followed by a return of the pin. This shows that the latch holds and that a one-bit end-of-interrupt clears only its own bit.
- Polarity rewrites while the pins are steady. These tell the intended edge-on-input design apart from detection on the polarity-adjusted signal, which would fire false events.
- A short glitch and then a long stable level on a debounced bit. These separate filtered inputs from unfiltered ones.

A second instance built with the alternate layout is probed at the offsets where the two layouts differ. Port registers are checked with distinct patterns in the first and the last port.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;

  typedef enum logic [3:0] {
    RK_NONE, RK_DATA, RK_DIR, RK_EXT, RK_IEN, RK_IMASK,
    RK_ITYPE, RK_IPOL, RK_ISTAT, RK_DBEN, RK_EOI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] port;
  } reg_sel_t;

  localparam int MAX_PORTS   = 4;
  localparam int PAIR_STRIDE = 12;
  localparam int EXT_BASE    = 'h50;
  localparam int EXT_STRIDE  = 4;

  function automatic reg_sel_t decode_offset(input logic [7:0] off,
                                             input bit alt,
                                             input int nports);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.port = 2'd0;
    for (int p = 0; p < MAX_PORTS; p++) begin
      if (p < nports) begin
        if (off == 8'(p * PAIR_STRIDE)) begin
          s.kind = RK_DATA; s.port = 2'(p);
        end
        if (off == 8'(p * PAIR_STRIDE + 4)) begin
          s.kind = RK_DIR; s.port = 2'(p);
        end
        if (off == 8'(EXT_BASE + p * EXT_STRIDE)) begin
          s.kind = RK_EXT; s.port = 2'(p);
        end
      end
    end
    if (off == 8'h30) s.kind = RK_IEN;
    if (off == 8'h48) s.kind = RK_DBEN;
    if (!alt) begin
      case (off)
        8'h34: s.kind = RK_IMASK;
        8'h38: s.kind = RK_ITYPE;
        8'h3c: s.kind = RK_IPOL;
        8'h40: s.kind = RK_ISTAT;
        8'h4c: s.kind = RK_EOI;
        default: ;
      endcase
    end else begin
      case (off)
        8'h34: s.kind = RK_ITYPE;
        8'h38: s.kind = RK_IPOL;
        8'h3c: s.kind = RK_ISTAT;
        8'h40: s.kind = RK_EOI;
        8'h44: s.kind = RK_IMASK;
        default: ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W     = 32,
  parameter int TICKS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] din,
  input  logic [W-1:0] en,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] cnt;
    logic          held;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt  <= '0;
        held <= 1'b0;
      end else if (!en[i]) begin
        held <= din[i];
        cnt  <= '0;
      end else if (din[i] == held) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          held <= din[i];
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign dout[i] = en[i] ? held : din[i];
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] qual_in,
  input  logic         wr_en,
  input  logic         wr_mask,
  input  logic         wr_type,
  input  logic         wr_pol,
  input  logic         wr_eoi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] type_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] status_q,
  output logic         irq_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] edge_hit;
  logic [W-1:0] level_hit;
  logic [W-1:0] clr_bits;
  logic [W-1:0] latch_d;
  logic [W-1:0] status_d;

  always_comb begin
    edge_hit  = (pol_q & qual_in & ~prev_q) | (~pol_q & ~qual_in & prev_q);
    level_hit = en_q & ~type_q & ~(qual_in ^ pol_q);
    clr_bits  = wr_eoi ? wdata : '0;
    latch_d   = en_q & type_q & (edge_hit | (latch_q & ~clr_bits));
    status_d  = (latch_d | level_hit) & ~mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      mask_q   <= '0;
      type_q   <= '0;
      pol_q    <= '0;
      prev_q   <= '0;
      latch_q  <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_en)   en_q   <= wdata;
      if (wr_mask) mask_q <= wdata;
      if (wr_type) type_q <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      prev_q   <= qual_in;
      latch_q  <= latch_d;
      status_q <= status_d;
      irq_q    <= |status_d;
    end
  end
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_W     = 32,
  parameter int ADDR_W     = 8,
  parameter bit ALT_LAYOUT = 1'b0,
  parameter int DB_TICKS   = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [31:0]                 pwdata,
  output logic [31:0]                 prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic                        db_tick,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  output logic                        irq
);
  localparam int PW = NUM_PORTS * PORT_W;

  logic [7:0]        off;
  logic              hi_ok;
  reg_sel_t          sel;
  reg_kind_e         kind;
  logic              wr_acc;
  logic              rd_setup;
  logic [PORT_W-1:0] wdata;
  logic [PW-1:0]     pin_s;

  assign off      = 8'(paddr);
  assign hi_ok    = ((paddr >> 8) == '0);
  assign sel      = decode_offset(off, ALT_LAYOUT, NUM_PORTS);
  assign kind     = hi_ok ? sel.kind : RK_NONE;
  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign wdata    = pwdata[PORT_W-1:0];
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;

  gpio_sync2 #(.W(PW)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(pin_s)
  );

  logic [PORT_W-1:0] data_arr [NUM_PORTS];
  logic [PORT_W-1:0] dir_arr  [NUM_PORTS];
  logic [PORT_W-1:0] ext_arr  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit_data;
    logic hit_dir;
    assign hit_data = wr_acc && (kind == RK_DATA) && (int'(sel.port) == p);
    assign hit_dir  = wr_acc && (kind == RK_DIR)  && (int'(sel.port) == p);

    gpio_port_bank #(.W(PORT_W)) u_bank (
      .clk(clk), .rst(rst), .wr_data(hit_data), .wr_dir(hit_dir),
      .wdata(wdata), .data_q(data_arr[p]), .dir_q(dir_arr[p])
    );

    assign pin_out[p*PORT_W +: PORT_W] = data_arr[p];
    assign pin_oe[p*PORT_W +: PORT_W]  = dir_arr[p];
    assign ext_arr[p]                  = pin_s[p*PORT_W +: PORT_W];
  end

  logic [PORT_W-1:0] dben_q;
  logic [PORT_W-1:0] qual_a;

  always_ff @(posedge clk) begin
    if (rst)                               dben_q <= '0;
    else if (wr_acc && kind == RK_DBEN)    dben_q <= wdata;
  end

  gpio_debounce #(.W(PORT_W), .TICKS(DB_TICKS)) u_deb (
    .clk(clk), .rst(rst), .tick(db_tick), .din(pin_s[PORT_W-1:0]),
    .en(dben_q), .dout(qual_a)
  );

  logic [PORT_W-1:0] irq_en;
  logic [PORT_W-1:0] irq_mask;
  logic [PORT_W-1:0] irq_type;
  logic [PORT_W-1:0] irq_pol;
  logic [PORT_W-1:0] irq_status;

  gpio_irq_unit #(.W(PORT_W)) u_irq (
    .clk(clk), .rst(rst), .qual_in(qual_a),
    .wr_en(wr_acc && kind == RK_IEN),
    .wr_mask(wr_acc && kind == RK_IMASK),
    .wr_type(wr_acc && kind == RK_ITYPE),
    .wr_pol(wr_acc && kind == RK_IPOL),
    .wr_eoi(wr_acc && kind == RK_EOI),
    .wdata(wdata),
    .en_q(irq_en), .mask_q(irq_mask), .type_q(irq_type), .pol_q(irq_pol),
    .status_q(irq_status), .irq_q(irq)
  );

  logic [31:0] rd_mux;
  int          pidx;

  always_comb begin
    pidx   = int'(sel.port);
    rd_mux = '0;
    case (kind)
      RK_DATA:  if (pidx < NUM_PORTS) rd_mux = 32'(data_arr[pidx]);
      RK_DIR:   if (pidx < NUM_PORTS) rd_mux = 32'(dir_arr[pidx]);
      RK_EXT:   if (pidx < NUM_PORTS) rd_mux = 32'(ext_arr[pidx]);
      RK_IEN:   rd_mux = 32'(irq_en);
      RK_IMASK: rd_mux = 32'(irq_mask);
      RK_ITYPE: rd_mux = 32'(irq_type);
      RK_IPOL:  rd_mux = 32'(irq_pol);
      RK_ISTAT: rd_mux = 32'(irq_status);
      RK_DBEN:  rd_mux = 32'(dben_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_apb_ctrl_sva.sv
module gpio_apb_ctrl_sva #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        psel,
  input logic                        penable,
  input logic                        pwrite,
  input logic [ADDR_W-1:0]           paddr,
  input logic [31:0]                 pwdata,
  input logic                        pready,
  input logic                        pslverr,
  input logic [NUM_PORTS*PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0]           status,
  input logic [PORT_W-1:0]           mask,
  input logic                        irq
);
  p_dr_write_r2: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite && paddr == '0)
      |=> (pin_out[PORT_W-1:0] == $past(pwdata[PORT_W-1:0])));

  p_no_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (pready && !pslverr));

  p_mask_hides_r8: assert property (@(posedge clk) disable iff (rst)
    ((status & $past(mask)) == '0));

  p_irq_or_r12: assert property (@(posedge clk) disable iff (rst)
    (irq == (|status)));
endmodule

bind gpio_apb_ctrl gpio_apb_ctrl_sva #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_sva (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
  .pin_out(pin_out), .status(irq_status), .mask(irq_mask), .irq(irq)
);

// File: tb/gpio_apb_ctrl_bench.sv
module gpio_apb_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int PWD = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          psel_m = 0, psel_a = 0, penable = 0, pwrite = 0;
  logic [7:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata_m, prdata_a;
  logic          pready_m, pslverr_m, pready_a, pslverr_a;
  logic          db_tick = 1'b0;
  logic [1:0]    tick_cnt = '0;
  logic [NP*PWD-1:0] pin_m = '0, pin_a = '0;
  logic [NP*PWD-1:0] out_m, oe_m, out_a, oe_a;
  logic          irq_m, irq_a;

  always @(posedge clk) begin
    tick_cnt <= tick_cnt + 2'd1;
    db_tick  <= (tick_cnt == 2'd3);
  end

  gpio_apb_ctrl #(.NUM_PORTS(NP), .PORT_W(PWD), .ALT_LAYOUT(1'b0), .DB_TICKS(4)) u_gpio_apb_ctrl (
    .clk(clk), .rst(rst), .psel(psel_m), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_m), .pready(pready_m),
    .pslverr(pslverr_m), .db_tick(db_tick), .pin_in(pin_m), .pin_out(out_m),
    .pin_oe(oe_m), .irq(irq_m)
  );

  gpio_apb_ctrl #(.NUM_PORTS(NP), .PORT_W(PWD), .ALT_LAYOUT(1'b1), .DB_TICKS(4)) u_gpio_apb_ctrl_alt (
    .clk(clk), .rst(rst), .psel(psel_a), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a),
    .pslverr(pslverr_a), .db_tick(db_tick), .pin_in(pin_a), .pin_out(out_a),
    .pin_oe(oe_a), .irq(irq_a)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // Monitor: pops expected read data at each read access phase
  always @(negedge clk) begin
    if ((psel_m || psel_a) && penable && !pwrite) begin
      logic [31:0] act;
      act = psel_a ? prdata_a : prdata_m;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard underflow act=%h exp=none", act);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          failures++;
          $display("FAIL %s act=%h exp=%h", t, act, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apb_wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel_m = !alt; psel_a = alt; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel_m = 0; psel_a = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input bit alt, input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    psel_m = !alt; psel_a = alt; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel_m = 0; psel_a = 0; penable = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 0;
    idle(2);

    // R1: reset state
    apb_rd(0, 8'h00, 32'h0, "R1 data0 after reset");
    apb_rd(0, 8'h40, 32'h0, "R1 status after reset");
    chk({31'd0, irq_m}, 32'h0, "R1 irq after reset");
    chk(oe_m[31:0], 32'h0, "R1 pin_oe after reset");

    // R2: port data/direction pairs
    apb_wr(0, 8'h00, 32'hA5A5_0F0F);
    apb_wr(0, 8'h04, 32'hFFFF_0000);
    apb_rd(0, 8'h00, 32'hA5A5_0F0F, "R2 port0 data readback");
    apb_rd(0, 8'h04, 32'hFFFF_0000, "R2 port0 dir readback");
    chk(out_m[31:0], 32'hA5A5_0F0F, "R2 port0 pin_out");
    chk(oe_m[31:0], 32'hFFFF_0000, "R2 port0 pin_oe");
    apb_wr(0, 8'h24, 32'h1357_9BDF);
    apb_wr(0, 8'h28, 32'h0000_FFFF);
    apb_rd(0, 8'h24, 32'h1357_9BDF, "R2 port3 data readback");
    chk(out_m[127:96], 32'h1357_9BDF, "R2 port3 pin_out");
    chk(oe_m[127:96], 32'h0000_FFFF, "R2 port3 pin_oe");
    chk(out_m[63:32], 32'h0, "R2 port1 untouched");

    // R3: external pin view
    pin_m[63:32] = 32'h1234_5678;
    idle(4);
    apb_rd(0, 8'h54, 32'h1234_5678, "R3 port1 ext read");
    apb_wr(0, 8'h54, 32'h0);
    apb_rd(0, 8'h54, 32'h1234_5678, "R3 ext write ignored");

    // R4: unmapped reads, no wait states
    apb_rd(0, 8'h08, 32'h0, "R4 unmapped 0x08");
    apb_rd(0, 8'h60, 32'h0, "R4 unmapped 0x60");
    apb_rd(0, 8'h44, 32'h0, "R4 unmapped 0x44 default layout");
    apb_rd(0, 8'h4c, 32'h0, "R4 eoi reads zero");
    chk({30'd0, pready_m, pslverr_m}, 32'h2, "R4 pready/pslverr");

    // R5: level sensing on bit 4
    apb_wr(0, 8'h3c, 32'h0000_0010);
    apb_wr(0, 8'h30, 32'h0000_0010);
    idle(4);
    apb_rd(0, 8'h40, 32'h0, "R5 level high inactive");
    pin_m[4] = 1'b1;
    idle(5);
    apb_rd(0, 8'h40, 32'h0000_0010, "R5 level high active");
    chk({31'd0, irq_m}, 32'h1, "R5 irq on level");
    pin_m[4] = 1'b0;
    idle(5);
    apb_rd(0, 8'h40, 32'h0, "R5 level released");
    apb_wr(0, 8'h3c, 32'h0);
    idle(4);
    apb_rd(0, 8'h40, 32'h0000_0010, "R5 active-low level");
    pin_m[4] = 1'b1;
    idle(5);
    apb_rd(0, 8'h40, 32'h0, "R5 active-low released");

    // R9: disabled line reports nothing
    pin_m[4] = 1'b0;
    apb_wr(0, 8'h30, 32'h0);
    idle(5);
    apb_rd(0, 8'h40, 32'h0, "R9 disabled level line");
    chk({31'd0, irq_m}, 32'h0, "R9 irq low when disabled");

    // R6: rising edges on bits 8 and 9
    apb_wr(0, 8'h38, 32'h0000_0300);
    apb_wr(0, 8'h3c, 32'h0000_0300);
    apb_wr(0, 8'h30, 32'h0000_0300);
    idle(4);
    pin_m[8] = 1'b1;
    idle(5);
    apb_rd(0, 8'h40, 32'h0000_0100, "R6 rising edge latched");
    pin_m[8] = 1'b0;
    pin_m[9] = 1'b1;
    idle(5);
    apb_rd(0, 8'h40, 32'h0000_0300, "R6 latch holds after pin low");
    apb_wr(0, 8'h40, 32'h0);
    apb_rd(0, 8'h40, 32'h0000_0300, "R12 status write ignored");
    chk({31'd0, irq_m}, 32'h1, "R12 irq with status set");
    apb_wr(0, 8'h4c, 32'h0000_0100);
    idle(2);
    apb_rd(0, 8'h40, 32'h0000_0200, "R6 eoi clears one bit");
    apb_wr(0, 8'h4c, 32'hFFFF_FFFF);
    idle(2);
    apb_rd(0, 8'h40, 32'h0, "R6 eoi all ones");
    chk({31'd0, irq_m}, 32'h0, "R12 irq low when status zero");

    // R7: polarity flips on steady pins, then a falling edge
    apb_wr(0, 8'h3c, 32'h0);
    idle(5);
    apb_rd(0, 8'h40, 32'h0, "R7 polarity change no false edge");
    pin_m[9] = 1'b0;
    idle(5);
    apb_rd(0, 8'h40, 32'h0000_0200, "R7 falling edge latched");
    apb_wr(0, 8'h4c, 32'hFFFF_FFFF);

    // R8: mask hides then reveals a latched edge
    apb_wr(0, 8'h3c, 32'h0000_0300);
    apb_wr(0, 8'h34, 32'h0000_0200);
    idle(3);
    pin_m[9] = 1'b1;
    idle(5);
    apb_rd(0, 8'h40, 32'h0, "R8 masked edge hidden");
    chk({31'd0, irq_m}, 32'h0, "R8 irq low while masked");
    apb_wr(0, 8'h34, 32'h0);
    idle(3);
    apb_rd(0, 8'h40, 32'h0000_0200, "R8 unmasked edge visible");
    chk({31'd0, irq_m}, 32'h1, "R8 irq after unmask");
    apb_wr(0, 8'h4c, 32'hFFFF_FFFF);

    // R9: edge on a disabled line
    apb_wr(0, 8'h30, 32'h0);
    idle(2);
    pin_m[8] = 1'b1;
    idle(5);
    apb_rd(0, 8'h40, 32'h0, "R9 disabled edge line");

    // R10: debounce on bit 1
    apb_wr(0, 8'h48, 32'h0000_0002);
    apb_rd(0, 8'h48, 32'h0000_0002, "R10 debounce enable readback");
    apb_wr(0, 8'h38, 32'h0000_0002);
    apb_wr(0, 8'h3c, 32'h0000_0002);
    apb_wr(0, 8'h30, 32'h0000_0002);
    idle(4);
    pin_m[1] = 1'b1;
    idle(6);
    pin_m[1] = 1'b0;
    idle(30);
    apb_rd(0, 8'h40, 32'h0, "R10 short pulse filtered");
    pin_m[1] = 1'b1;
    idle(40);
    apb_rd(0, 8'h40, 32'h0000_0002, "R10 stable level accepted");
    apb_wr(0, 8'h4c, 32'hFFFF_FFFF);

    // R11: alternate layout
    apb_wr(1, 8'h34, 32'h1);
    apb_wr(1, 8'h38, 32'h1);
    apb_wr(1, 8'h30, 32'h1);
    apb_wr(1, 8'h44, 32'h0000_0080);
    apb_rd(1, 8'h44, 32'h0000_0080, "R11 alt mask at 0x44");
    apb_rd(1, 8'h34, 32'h1, "R11 alt type at 0x34");
    idle(2);
    pin_a[0] = 1'b1;
    idle(5);
    apb_rd(1, 8'h3c, 32'h1, "R11 alt status at 0x3c");
    apb_rd(1, 8'h40, 32'h0, "R11 alt 0x40 is eoi");
    chk({31'd0, irq_a}, 32'h1, "R11 alt irq");
    apb_wr(1, 8'h40, 32'h1);
    idle(2);
    apb_rd(1, 8'h3c, 32'h0, "R11 alt eoi clears");

    idle(3);
    chk(32'(exp_q.size()), 32'h0, "R1 scoreboard drained");
    finish_run();
  end
endmodule